// File: doc/BRIEF.md
# Processor Exception Entry Unit

This block decides, every clock, whether the processor must leave its current instruction stream for an exception handler. It looks at a reset request, a hardware-error request, five synchronous fault flags raised by the pipeline and six external interrupt lines. Each interrupt line is gated by its own mask bit and by a global interrupt-enable. When one of these sources wins, the block does several things in one step. It selects the fixed handler address for that class of event and saves either the address of the offending instruction or the address of the one after it. It records a cause code for the handler to read, clears the global interrupt-enable and forces kernel mode. It then issues a one-cycle redirect carrying the new fetch address.

A return-from-exception request drops back to user mode, sets the global interrupt-enable again and redirects fetch to the saved exception address. Everything the block drives is registered, so every event shows on the outputs one clock after the inputs that caused it.

Top module: `exc_entry_unit`

## Requirements
- R1: While `rst_n` is low and after it rises (with no request), `kernel_mode`=1, `int_enable`=0, `epc`=0, `cause`=0 and `redirect_valid`=0.
- R2: Source priority is fixed: `reset_req` wins over `hw_err`, which wins over any `sync_flags` bit, which wins over a qualified interrupt. Only the winning source decides vector, cause and saved address.
- R3: With the default 64-bit PC the handler addresses are: base 0xFFFF_FFFF_BFC0_0000 for a reset request, base+0x300 for a hardware error, base+0x380 for an interrupt and base+0x400 for any synchronous fault.
- R4: `epc` is loaded with `cur_pc` for a hardware error, address error, reserved instruction or overflow. It is loaded with `next_pc` for a system call, trap or interrupt, and it keeps its value on a reset request.
- R5: `cause` codes are: 1 reset request, 2 hardware error, 3 interrupt, 4 address error, 5 reserved instruction, 6 overflow, 7 system call, 8 trap.
- R6: An interrupt is taken only when some `irq_lines` bit has its `irq_mask` bit set and `int_enable` is 1. Otherwise the lines do not redirect and do not change `epc` or `cause`.
- R7: A taken exception gives `kernel_mode`=1, `int_enable`=0 and `redirect_valid`=1 for exactly one cycle, all starting on the clock edge that samples the request.
- R8: When `eret` is sampled with no exception, `kernel_mode` goes to 0, `int_enable` goes to 1 and `redirect_pc` is the `epc` value held before that edge, for a one-cycle redirect. If an exception is sampled on the same edge, the exception is taken and `eret` is ignored.
- R9: `sync_flags` bits are [0] address error, [1] reserved instruction, [2] overflow, [3] system call, [4] trap. When several are set, the lowest-numbered set bit wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reset_req | input | 1 | Soft reset request |
| hw_err | input | 1 | Hardware error request |
| sync_flags | input | 5 | Synchronous fault flags from the pipeline |
| irq_lines | input | 6 | External interrupt lines |
| irq_mask | input | 6 | Per-line interrupt mask, 1 = allowed |
| eret | input | 1 | Return-from-exception request |
| cur_pc | input | 64 | Address of the instruction in the faulting stage |
| next_pc | input | 64 | Address of the following instruction |
| redirect_valid | output | 1 | One-cycle fetch redirect pulse |
| redirect_pc | output | 64 | Redirect target |
| epc | output | 64 | Saved exception address |
| cause | output | 4 | Cause code of the last exception taken |
| kernel_mode | output | 1 | 1 = kernel mode |
| int_enable | output | 1 | Global interrupt-enable |

## Verification
The hardest state to reach is an interrupt that is actually taken. The global enable comes out of reset cleared, and every exception clears it again, so the only way to set it is a return-from-exception. The directed stimulus therefore issues `eret` before each interrupt scenario. It also raises interrupt lines both while the enable is clear and while their mask bits are clear, to show that nothing is taken in either case. Collisions are driven in one cycle: all sources raised together, and `eret` raised together with a synchronous fault.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int SYNC_N = 5;
    localparam int IRQ_N  = 6;

    // Bit positions inside the synchronous fault vector.
    localparam int SF_ADDR    = 0;
    localparam int SF_RESV    = 1;
    localparam int SF_OVF     = 2;
    localparam int SF_SYSCALL = 3;
    localparam int SF_TRAP    = 4;

    typedef enum logic [2:0] {
        CLS_NONE  = 3'd0,
        CLS_RESET = 3'd1,
        CLS_HWERR = 3'd2,
        CLS_SYNC  = 3'd3,
        CLS_IRQ   = 3'd4
    } exc_class_e;

    typedef enum logic [3:0] {
        CAUSE_NONE    = 4'd0,
        CAUSE_RESET   = 4'd1,
        CAUSE_HWERR   = 4'd2,
        CAUSE_IRQ     = 4'd3,
        CAUSE_ADDR    = 4'd4,
        CAUSE_RESV    = 4'd5,
        CAUSE_OVF     = 4'd6,
        CAUSE_SYSCALL = 4'd7,
        CAUSE_TRAP    = 4'd8
    } cause_e;

    // Offsets of each handler from the reset base.
    localparam logic [15:0] OFS_RESET = 16'h0000;
    localparam logic [15:0] OFS_HWERR = 16'h0300;
    localparam logic [15:0] OFS_IRQ   = 16'h0380;
    localparam logic [15:0] OFS_SYNC  = 16'h0400;

endpackage

// File: rtl/exc_prio_sel.sv
module exc_prio_sel
    import exc_entry_pkg::*;
#(
    parameter int SYNC_W = SYNC_N,
    parameter int IRQ_W  = IRQ_N,
    // 1 = this synchronous fault saves the following instruction.
    parameter logic [SYNC_W-1:0] SAVE_NEXT_MASK = SYNC_W'(5'b11000)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reset_req,
    input  logic              hw_err,
    input  logic [SYNC_W-1:0] sync_flags,
    input  logic [IRQ_W-1:0]  irq_lines,
    input  logic [IRQ_W-1:0]  irq_mask,
    input  logic              int_en,
    output logic              take,
    output exc_class_e        cls,
    output cause_e            cause_sel,
    output logic              save_next
);
    localparam int IDX_W = (SYNC_W > 1) ? $clog2(SYNC_W) : 1;

    logic             sync_hit;
    logic [IDX_W-1:0] sync_idx;
    logic             irq_hit;

    // Lowest set fault bit wins: scan downward so the last hit is the lowest.
    always_comb begin
        sync_hit = 1'b0;
        sync_idx = '0;
        for (int i = SYNC_W - 1; i >= 0; i--) begin
            if (sync_flags[i]) begin
                sync_hit = 1'b1;
                sync_idx = IDX_W'(i);
            end
        end
    end

    assign irq_hit = int_en && (|(irq_lines & irq_mask));

    always_comb begin
        cls       = CLS_NONE;
        cause_sel = CAUSE_NONE;
        save_next = 1'b0;
        if (reset_req) begin
            cls       = CLS_RESET;
            cause_sel = CAUSE_RESET;
        end else if (hw_err) begin
            cls       = CLS_HWERR;
            cause_sel = CAUSE_HWERR;
        end else if (sync_hit) begin
            cls       = CLS_SYNC;
            cause_sel = cause_e'(4'(CAUSE_ADDR) + 4'(sync_idx));
            save_next = SAVE_NEXT_MASK[sync_idx];
        end else if (irq_hit) begin
            cls       = CLS_IRQ;
            cause_sel = CAUSE_IRQ;
            save_next = 1'b1;
        end
    end

    assign take = (cls != CLS_NONE);

    // R6: an interrupt grant needs the enable from the top and a masked line.
    assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == CLS_IRQ) |-> (int_en && (|(irq_lines & irq_mask))));

    // R2: a lower-priority grant never coexists with a higher request.
    assert_prio_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == CLS_SYNC || cls == CLS_IRQ) |-> (!reset_req && !hw_err));

    // R9: the chosen fault flag is set and no lower-numbered one is.
    assert_sync_lowest_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == CLS_SYNC) |-> (sync_flags[sync_idx] &&
            ((sync_flags & ((SYNC_W'(1) << sync_idx) - SYNC_W'(1))) == '0)));

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
    import exc_entry_pkg::*;
#(
    parameter int PC_W = 64
) (
    input  exc_class_e      cls,
    output logic [PC_W-1:0] vector
);
    logic [PC_W-1:0] base;

    // Wider PCs sign-extend the 32-bit base with ones.
    generate
        if (PC_W > 32) begin : g_wide
            assign base = {{(PC_W - 32){1'b1}}, 32'hBFC0_0000};
        end else begin : g_narrow
            localparam logic [31:0] BASE32 = 32'hBFC0_0000;
            assign base = BASE32[PC_W-1:0];
        end
    endgenerate

    logic [15:0] ofs;

    always_comb begin
        unique case (cls)
            CLS_HWERR: ofs = OFS_HWERR;
            CLS_IRQ:   ofs = OFS_IRQ;
            CLS_SYNC:  ofs = OFS_SYNC;
            default:   ofs = OFS_RESET;
        endcase
    end

    assign vector = base + PC_W'(ofs);

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_entry_pkg::*;
#(
    parameter int PC_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reset_req,
    input  logic             hw_err,
    input  logic [4:0]       sync_flags,
    input  logic [5:0]       irq_lines,
    input  logic [5:0]       irq_mask,
    input  logic             eret,
    input  logic [PC_W-1:0]  cur_pc,
    input  logic [PC_W-1:0]  next_pc,
    output logic             redirect_valid,
    output logic [PC_W-1:0]  redirect_pc,
    output logic [PC_W-1:0]  epc,
    output logic [3:0]       cause,
    output logic             kernel_mode,
    output logic             int_enable
);
    typedef struct packed {
        logic            kernel;
        logic            ie;
        logic [PC_W-1:0] epc;
        cause_e          cause;
        logic            redir_v;
        logic [PC_W-1:0] redir_pc;
    } state_t;

    state_t     st_d, st_q;
    logic       take_d;
    exc_class_e cls_d;
    cause_e     cause_sel_d;
    logic       save_next_d;
    logic [PC_W-1:0] vector_d;

    exc_prio_sel #(
        .SYNC_W (SYNC_N),
        .IRQ_W  (IRQ_N)
    ) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .reset_req  (reset_req),
        .hw_err     (hw_err),
        .sync_flags (sync_flags),
        .irq_lines  (irq_lines),
        .irq_mask   (irq_mask),
        .int_en     (st_q.ie),
        .take       (take_d),
        .cls        (cls_d),
        .cause_sel  (cause_sel_d),
        .save_next  (save_next_d)
    );

    exc_vector_gen #(
        .PC_W (PC_W)
    ) u_vec (
        .cls    (cls_d),
        .vector (vector_d)
    );

    always_comb begin
        st_d         = st_q;
        st_d.redir_v = 1'b0;
        if (take_d) begin
            st_d.kernel   = 1'b1;
            st_d.ie       = 1'b0;
            st_d.cause    = cause_sel_d;
            st_d.redir_v  = 1'b1;
            st_d.redir_pc = vector_d;
            if (cls_d != CLS_RESET) begin
                st_d.epc = save_next_d ? next_pc : cur_pc;
            end
        end else if (eret) begin
            st_d.kernel   = 1'b0;
            st_d.ie       = 1'b1;
            st_d.redir_v  = 1'b1;
            st_d.redir_pc = st_q.epc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.kernel   <= 1'b1;
            st_q.ie       <= 1'b0;
            st_q.epc      <= '0;
            st_q.cause    <= CAUSE_NONE;
            st_q.redir_v  <= 1'b0;
            st_q.redir_pc <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign redirect_valid = st_q.redir_v;
    assign redirect_pc    = st_q.redir_pc;
    assign epc            = st_q.epc;
    assign cause          = st_q.cause;
    assign kernel_mode    = st_q.kernel;
    assign int_enable     = st_q.ie;

    assert_take_kernel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take_d |=> (kernel_mode && !int_enable && redirect_valid));

    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_d && !eret) |=> !redirect_valid);

    assert_eret_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eret && !take_d) |=> (!kernel_mode && int_enable &&
                               redirect_pc == $past(epc)));

    assert_reset_keeps_epc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_d == CLS_RESET) |=> $stable(epc));

    assert_save_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take_d && cls_d != CLS_RESET && !save_next_d) |=> (epc == $past(cur_pc)));

endmodule

// File: tb/tb_exc_entry_unit.sv
module tb_exc_entry_unit;
    localparam logic [63:0] BASE = 64'hFFFF_FFFF_BFC0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reset_req = 1'b0;
    logic        hw_err = 1'b0;
    logic [4:0]  sync_flags = '0;
    logic [5:0]  irq_lines = '0;
    logic [5:0]  irq_mask = '0;
    logic        eret = 1'b0;
    logic [63:0] cur_pc = '0;
    logic [63:0] next_pc = '0;
    logic        redirect_valid;
    logic [63:0] redirect_pc;
    logic [63:0] epc;
    logic [3:0]  cause;
    logic        kernel_mode;
    logic        int_enable;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    exc_entry_unit dut (
        .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .hw_err(hw_err),
        .sync_flags(sync_flags), .irq_lines(irq_lines), .irq_mask(irq_mask),
        .eret(eret), .cur_pc(cur_pc), .next_pc(next_pc),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .epc(epc),
        .cause(cause), .kernel_mode(kernel_mode), .int_enable(int_enable)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs at a falling edge, release them at the next.
    task automatic apply(input bit rr, input bit he, input logic [4:0] sf,
                         input logic [5:0] il, input logic [5:0] im, input bit er,
                         input logic [63:0] cp, input logic [63:0] np);
        @(negedge clk);
        reset_req = rr; hw_err = he; sync_flags = sf; irq_lines = il;
        irq_mask = im; eret = er; cur_pc = cp; next_pc = np;
        @(negedge clk);
        reset_req = 0; hw_err = 0; sync_flags = '0; irq_lines = '0; eret = 0;
    endtask

    task automatic expect_taken(input string req, input logic [63:0] vec,
                                input logic [3:0] cs, input logic [63:0] ep);
        check({req, " redirect_valid"}, 64'(redirect_valid), 64'd1);
        check({req, " vector"}, redirect_pc, vec);
        check({req, " cause"}, 64'(cause), 64'(cs));
        check({req, " epc"}, epc, ep);
        check({req, " R7 kernel"}, 64'(kernel_mode), 64'd1);
        check({req, " R7 ie"}, 64'(int_enable), 64'd0);
        @(negedge clk);
        check({req, " R7 pulse drops"}, 64'(redirect_valid), 64'd0);
    endtask

    task automatic do_eret(input logic [63:0] exp_target);
        apply(0, 0, '0, '0, irq_mask, 1, '0, '0);
        check("R8 redirect_valid", 64'(redirect_valid), 64'd1);
        check("R8 target", redirect_pc, exp_target);
        check("R8 kernel", 64'(kernel_mode), 64'd0);
        check("R8 ie", 64'(int_enable), 64'd1);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 kernel", 64'(kernel_mode), 64'd1);
        check("R1 ie", 64'(int_enable), 64'd0);
        check("R1 epc", epc, 64'd0);
        check("R1 cause", 64'(cause), 64'd0);
        check("R1 redirect", 64'(redirect_valid), 64'd0);
    endtask

    task automatic t_irq();
        do_eret(64'd0);
        // Line active but mask clear: nothing taken (R6).
        apply(0, 0, '0, 6'b000100, 6'b000000, 0, 64'h100, 64'h104);
        check("R6 masked no redirect", 64'(redirect_valid), 64'd0);
        check("R6 masked cause kept", 64'(cause), 64'd0);
        check("R6 masked ie kept", 64'(int_enable), 64'd1);
        apply(0, 0, '0, 6'b100100, 6'b100000, 0, 64'h200, 64'h204);
        expect_taken("R3 R4 R5 irq", BASE + 64'h380, 4'd3, 64'h204);
        // Enable now clear: interrupt ignored (R6).
        apply(0, 0, '0, 6'b100000, 6'b100000, 0, 64'h300, 64'h304);
        check("R6 ie clear no redirect", 64'(redirect_valid), 64'd0);
        check("R6 ie clear epc kept", epc, 64'h204);
        do_eret(64'h204);
    endtask

    task automatic t_sync();
        apply(0, 0, 5'b00001, '0, '0, 0, 64'h1000, 64'h1004);
        expect_taken("R3 R4 addr", BASE + 64'h400, 4'd4, 64'h1000);
        apply(0, 0, 5'b11110, '0, '0, 0, 64'h1100, 64'h1104);
        expect_taken("R9 resv wins", BASE + 64'h400, 4'd5, 64'h1100);
        apply(0, 0, 5'b11100, '0, '0, 0, 64'h1200, 64'h1204);
        expect_taken("R9 ovf", BASE + 64'h400, 4'd6, 64'h1200);
        apply(0, 0, 5'b11000, '0, '0, 0, 64'h1300, 64'h1304);
        expect_taken("R4 R9 syscall", BASE + 64'h400, 4'd7, 64'h1304);
        apply(0, 0, 5'b10000, '0, '0, 0, 64'h1400, 64'h1404);
        expect_taken("R4 R5 trap", BASE + 64'h400, 4'd8, 64'h1404);
    endtask

    task automatic t_priority();
        do_eret(64'h1404);
        apply(0, 1, 5'b01000, 6'h3F, 6'h3F, 0, 64'h2000, 64'h2004);
        expect_taken("R2 hw_err", BASE + 64'h300, 4'd2, 64'h2000);
        do_eret(64'h2000);
        apply(0, 0, 5'b01000, 6'h3F, 6'h3F, 0, 64'h2100, 64'h2104);
        expect_taken("R2 sync over irq", BASE + 64'h400, 4'd7, 64'h2104);
        apply(1, 1, 5'b11111, 6'h3F, 6'h3F, 1, 64'h2200, 64'h2204);
        expect_taken("R2 R4 reset_req", BASE, 4'd1, 64'h2104);
    endtask

    task automatic t_eret_collide();
        apply(0, 0, 5'b00100, '0, '0, 1, 64'h3000, 64'h3004);
        expect_taken("R8 exception beats eret", BASE + 64'h400, 4'd6, 64'h3000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_irq();
        t_sync();
        t_priority();
        t_eret_collide();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule